// File: doc/BRIEF.md
# Dual-Lane Serial Lock-Register Slave

This block is the target side of a serial memory link in which every phase of a frame moves two bits per serial clock over two data lanes, lane 1 carrying the odd-numbered bit of each pair and lane 0 the even-numbered one, most significant pair first. A frame opens when the active-low select falls. It is made of a 4-clock command byte, an optional 12-clock address and then data. The block knows three commands: one that arms a write-enable latch, one that returns a lock register, and one that updates a lock register. It holds an array of 128 two-bit lock registers, one per sector, indexed by address bits 22..16. Address bit 23 plays no part.

The serial pins are oversampled in a fast system clock. Lane inputs are taken on the serial clock's rising edge and read data is launched on its falling edge. Writes and the write-enable latch take effect only when the select rises exactly at the end of a byte. A debug read port exposes any lock register and the latch state so that a testbench can observe the register file directly. The serial pins are a fixed-timing link, so they carry no valid/ready handshake and the master cannot apply back-pressure.

Top module: `dual_lane_lock_slave`

## Requirements
- R1: After reset every lock register reads 0x00, the write-enable latch is 0 and both lane enables are 0.
- R2: A frame holding only the command byte 0x06 (4 clocks, pair bits 7:6 first, odd bit on dq[1]) sets the write-enable latch when the select rises right after the 4th clock.
- R3: Command 0xE5, then 12 address clocks, then one 4-clock data byte, with the select rising right after the byte, stores data bits 1:0 into the register indexed by address bits 22..16 and clears the write-enable latch, provided the latch was set.
- R4: A 0xE5 frame sent while the write-enable latch is 0 leaves every register and the latch unchanged.
- R5: A 0xE5 frame whose select rises partway through a data byte changes no register and leaves the latch set.
- R6: Command 0xE8 plus 12 address clocks makes the block drive the indexed register on the next 4 clocks (clocks 16..19), bits 7:6 first with bit 7 on dq[1], upper six bits as zeros.
- R7: Address bit 23 is ignored: addresses that differ only in bit 23 select the same register.
- R8: Lane enables are 0 whenever the select is high and during the command and address phases of every frame.
- R9: A frame with any other command byte is ignored until the select rises: no register or latch change and no driven lane.
- R10: A 0x06 frame with any clock beyond the 4th does not set the latch.
- R11: When a write frame carries several complete data bytes, the last byte is stored.
- R12: Clocking a read past 4 data clocks repeats the same register value from bits 7:6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low reset |
| sclk | input | 1 | Serial clock |
| cs_n | input | 1 | Active-low frame select |
| dq_in | input | 2 | Lane inputs; bit 1 odd bit, bit 0 even bit |
| dq_out | output | 2 | Lane outputs during read data |
| dq_oe | output | 2 | Lane output enables; lanes are high-impedance when 0 |
| dbg_idx | input | 7 | Debug register index |
| dbg_lock | output | 8 | Debug view of the indexed lock register |
| dbg_wel | output | 1 | Debug view of the write-enable latch |

## Verification
The bench targets the frame-ending corner cases. A select rising mid-byte must not commit, where a faulty design would store a half-shifted value. A write-enable frame with one stray clock must not arm the latch. A write without the latch must be dropped, where a faulty design would update the register anyway. It also checks that bit 23 is discarded, since a design that kept it would index the wrong sector. It checks that unknown commands and the command and address phases of a read never turn on the lanes, and that a read clocked past its byte wraps to bits 7:6 rather than shifting out zeros.

// File: rtl/lockreg_pkg.sv
package lockreg_pkg;
  localparam int LANES      = 2;
  localparam int BYTE_W     = 8;
  localparam int BYTE_PAIRS = BYTE_W / LANES;
  localparam int LOCK_BITS  = LANES;

  typedef enum logic [2:0] {
    PH_CMD,
    PH_WEL_DONE,
    PH_ADDR,
    PH_DATA,
    PH_SKIP
  } phase_t;
endpackage

// File: rtl/lr_pin_sync.sv
module lr_pin_sync #(
  parameter int         W       = 4,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[b]}};
      else        chain <= {chain[STAGES-2:0], async_in[b]};
    end
    assign sync_out[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/lr_frame_decoder.sv
module lr_frame_decoder
  import lockreg_pkg::*;
#(
  parameter int         ADDR_W   = 24,
  parameter int         IDX_LSB  = 16,
  parameter int         IDX_W    = ADDR_W - 1 - IDX_LSB,
  parameter logic [7:0] OPC_WREN = 8'h06,
  parameter logic [7:0] OPC_RDLR = 8'hE8,
  parameter logic [7:0] OPC_WRLR = 8'hE5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  sclk_s,
  input  logic                  cs_n_s,
  input  logic [LANES-1:0]      dq_s,
  output logic                  sclk_fall,
  output logic                  cs_rise,
  output logic                  wren_commit,
  output logic                  wr_request,
  output logic [IDX_W-1:0]      idx,
  output logic [LOCK_BITS-1:0]  wr_data,
  output logic                  rd_active,
  output logic [1:0]            pair_idx
);
  localparam int ADDR_PAIRS = ADDR_W / LANES;
  localparam int HI_PAIRS   = (ADDR_W - IDX_LSB) / LANES;
  localparam int ACNT_W     = $clog2(ADDR_PAIRS);
  localparam logic [ACNT_W-1:0] ACNT_LAST = ACNT_W'(ADDR_PAIRS - 1);
  localparam logic [ACNT_W-1:0] ACNT_HI   = ACNT_W'(HI_PAIRS);

  phase_t                 phase;
  logic [1:0]             pair;
  logic [ACNT_W-1:0]      acnt;
  logic [BYTE_W-3:0]      op_sh;
  logic                   is_read;
  logic [IDX_W-1:0]       hi_sh;
  logic [LOCK_BITS-1:0]   lock_q;
  logic                   byte_seen;
  logic                   sclk_q, cs_q;
  logic                   rise;
  logic [BYTE_W-1:0]      opc;

  assign rise      = sclk_s & ~sclk_q & ~cs_n_s;
  assign sclk_fall = ~sclk_s & sclk_q & ~cs_n_s;
  assign cs_rise   = cs_n_s & ~cs_q;
  assign opc       = {op_sh, dq_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_CMD;
      pair      <= '0;
      acnt      <= '0;
      op_sh     <= '0;
      is_read   <= 1'b0;
      hi_sh     <= '0;
      lock_q    <= '0;
      byte_seen <= 1'b0;
      sclk_q    <= 1'b0;
      cs_q      <= 1'b1;
    end else begin
      sclk_q <= sclk_s;
      cs_q   <= cs_n_s;
      if (cs_n_s) begin
        phase     <= PH_CMD;
        pair      <= '0;
        acnt      <= '0;
        is_read   <= 1'b0;
        byte_seen <= 1'b0;
      end else if (rise) begin
        case (phase)
          PH_CMD: begin
            op_sh <= {op_sh[BYTE_W-5:0], dq_s};
            pair  <= pair + 2'd1;
            if (pair == 2'd3) begin
              if (opc == OPC_WREN) begin
                phase <= PH_WEL_DONE;
              end else if (opc == OPC_RDLR) begin
                phase   <= PH_ADDR;
                is_read <= 1'b1;
              end else if (opc == OPC_WRLR) begin
                phase <= PH_ADDR;
              end else begin
                phase <= PH_SKIP;
              end
            end
          end
          PH_ADDR: begin
            if (acnt < ACNT_HI) hi_sh <= {hi_sh[IDX_W-3:0], dq_s};
            if (acnt == ACNT_LAST) begin
              acnt  <= '0;
              phase <= PH_DATA;
            end else begin
              acnt <= acnt + 1'b1;
            end
          end
          PH_DATA: begin
            pair <= pair + 2'd1;
            if (pair == 2'd3) begin
              lock_q    <= dq_s;
              byte_seen <= 1'b1;
            end
          end
          PH_WEL_DONE: phase <= PH_SKIP;
          default: ;
        endcase
      end
    end
  end

  assign wren_commit = cs_rise & (phase == PH_WEL_DONE);
  assign wr_request  = cs_rise & (phase == PH_DATA) & ~is_read & byte_seen & (pair == 2'd0);
  assign rd_active   = (phase == PH_DATA) & is_read;
  assign idx         = hi_sh;
  assign wr_data     = lock_q;
  assign pair_idx    = pair;
endmodule

// File: rtl/lr_lock_file.sv
module lr_lock_file
  import lockreg_pkg::*;
#(
  parameter int IDX_W = 7
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wren_commit,
  input  logic                 wr_request,
  input  logic [IDX_W-1:0]     wr_idx,
  input  logic [LOCK_BITS-1:0] wr_data,
  input  logic [IDX_W-1:0]     rd_idx,
  output logic [BYTE_W-1:0]    rd_byte,
  input  logic [IDX_W-1:0]     dbg_idx,
  output logic [BYTE_W-1:0]    dbg_byte,
  output logic                 wel
);
  localparam int DEPTH = 1 << IDX_W;

  logic [LOCK_BITS-1:0] mem [DEPTH];
  logic                 wr_accept;

  assign wr_accept = wr_request & wel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_accept) begin
      mem[wr_idx] <= wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           wel <= 1'b0;
    else if (wr_accept)   wel <= 1'b0;
    else if (wren_commit) wel <= 1'b1;
  end

  assign rd_byte  = {{(BYTE_W-LOCK_BITS){1'b0}}, mem[rd_idx]};
  assign dbg_byte = {{(BYTE_W-LOCK_BITS){1'b0}}, mem[dbg_idx]};
endmodule

// File: rtl/lr_out_driver.sv
module lr_out_driver
  import lockreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n_raw,
  input  logic              cs_n_s,
  input  logic              sclk_fall,
  input  logic              rd_active,
  input  logic [1:0]        pair_idx,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic [LANES-1:0]  dq_out,
  output logic [LANES-1:0]  dq_oe
);
  logic              oe_r;
  logic [LANES-1:0]  dq_r;
  logic [BYTE_W-1:0] aligned;

  assign aligned = rd_byte << (LANES * pair_idx);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      oe_r <= 1'b0;
      dq_r <= '0;
    end else if (cs_n_s) begin
      oe_r <= 1'b0;
    end else if (sclk_fall) begin
      oe_r <= rd_active;
      dq_r <= aligned[BYTE_W-1 -: LANES];
    end
  end

  assign dq_out = dq_r;
  assign dq_oe  = {LANES{oe_r & ~cs_n_raw}};
endmodule

// File: rtl/dual_lane_lock_slave.sv
module dual_lane_lock_slave
  import lockreg_pkg::*;
#(
  parameter int         SYNC_STAGES = 2,
  parameter int         ADDR_W      = 24,
  parameter int         IDX_LSB     = 16,
  parameter logic [7:0] OPC_WREN    = 8'h06,
  parameter logic [7:0] OPC_RDLR    = 8'hE8,
  parameter logic [7:0] OPC_WRLR    = 8'hE5
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      sclk,
  input  logic                      cs_n,
  input  logic [1:0]                dq_in,
  output logic [1:0]                dq_out,
  output logic [1:0]                dq_oe,
  input  logic [ADDR_W-2-IDX_LSB:0] dbg_idx,
  output logic [7:0]                dbg_lock,
  output logic                      dbg_wel
);
  localparam int IDX_W  = ADDR_W - 1 - IDX_LSB;
  localparam int SYNC_W = LANES + 2;

  logic [SYNC_W-1:0]    pins_s;
  logic                 sclk_s, cs_n_s;
  logic [LANES-1:0]     dq_s;
  logic                 sclk_fall, cs_rise, wren_commit, wr_request, rd_active;
  logic [IDX_W-1:0]     idx;
  logic [LOCK_BITS-1:0] wr_data;
  logic [1:0]           pair_idx;
  logic [BYTE_W-1:0]    rd_byte;

  lr_pin_sync #(
    .W(SYNC_W), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_W'(1) << (SYNC_W-1))
  ) i_sync (
    .clk(clk), .rst_n(rst_n),
    .async_in({cs_n, sclk, dq_in}),
    .sync_out(pins_s)
  );

  assign cs_n_s = pins_s[SYNC_W-1];
  assign sclk_s = pins_s[SYNC_W-2];
  assign dq_s   = pins_s[LANES-1:0];

  lr_frame_decoder #(
    .ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB), .IDX_W(IDX_W),
    .OPC_WREN(OPC_WREN), .OPC_RDLR(OPC_RDLR), .OPC_WRLR(OPC_WRLR)
  ) i_dec (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_n_s(cs_n_s), .dq_s(dq_s),
    .sclk_fall(sclk_fall), .cs_rise(cs_rise), .wren_commit(wren_commit),
    .wr_request(wr_request), .idx(idx), .wr_data(wr_data),
    .rd_active(rd_active), .pair_idx(pair_idx)
  );

  lr_lock_file #(.IDX_W(IDX_W)) i_file (
    .clk(clk), .rst_n(rst_n), .wren_commit(wren_commit), .wr_request(wr_request),
    .wr_idx(idx), .wr_data(wr_data), .rd_idx(idx), .rd_byte(rd_byte),
    .dbg_idx(dbg_idx), .dbg_byte(dbg_lock), .wel(dbg_wel)
  );

  lr_out_driver i_out (
    .clk(clk), .rst_n(rst_n), .cs_n_raw(cs_n), .cs_n_s(cs_n_s),
    .sclk_fall(sclk_fall), .rd_active(rd_active), .pair_idx(pair_idx),
    .rd_byte(rd_byte), .dq_out(dq_out), .dq_oe(dq_oe)
  );
endmodule

// File: rtl/lr_slave_checker.sv
module lr_slave_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic [1:0] dq_oe,
  input logic       wel,
  input logic       cs_rise,
  input logic       wr_request,
  input logic       rd_active
);
  a_r8_quiet_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> dq_oe == 2'b00);

  a_r8_drive_only_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe != 2'b00) |-> rd_active);

  a_r2_wel_sets_at_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel) |-> $past(cs_rise));

  a_r3_wel_clears_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wel) |-> $past(wr_request));
endmodule

bind dual_lane_lock_slave lr_slave_checker i_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dq_oe(dq_oe), .wel(dbg_wel),
  .cs_rise(cs_rise), .wr_request(wr_request), .rd_active(rd_active)
);

// File: tb/test_dual_lane_lock_slave.sv
module test_dual_lane_lock_slave;
  localparam int HALF = 8;
  localparam logic [7:0] C_WREN = 8'h06, C_RD = 8'hE8, C_WR = 8'hE5;
  // {kind(0 write,1 read), addr, data, expected register value}
  localparam logic [41:0] VEC [7] = '{
    {2'd0, 24'h050000, 8'hFF, 8'h03},
    {2'd1, 24'h850000, 8'h00, 8'h03},
    {2'd0, 24'h7F0000, 8'hA6, 8'h02},
    {2'd1, 24'h7F1234, 8'h00, 8'h02},
    {2'd0, 24'h800000, 8'h01, 8'h01},
    {2'd1, 24'h000000, 8'h00, 8'h01},
    {2'd1, 24'h050000, 8'h00, 8'h03}
  };

  logic       clk = 0, rst_n = 0, sclk = 0, cs_n = 1;
  logic [1:0] dq_in = 0, dq_out, dq_oe;
  logic [6:0] dbg_idx = 0;
  logic [7:0] dbg_lock;
  logic       dbg_wel;
  int total = 0, bad = 0, oe_cnt = 0, hdr_oe = 0;
  bit done = 0;

  dual_lane_lock_slave i_dual_lane_lock_slave (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .dq_in(dq_in),
    .dq_out(dq_out), .dq_oe(dq_oe), .dbg_idx(dbg_idx), .dbg_lock(dbg_lock),
    .dbg_wel(dbg_wel)
  );

  always #2.5 clk = ~clk;
  always @(negedge clk) if (dq_oe != 2'b00) oe_cnt++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pair(input logic [1:0] v, output logic [1:0] got);
    dq_in = v;
    waitc(HALF);
    got = dq_out;
    sclk = 1;
    waitc(HALF);
    sclk = 0;
  endtask

  task automatic send_byte(input logic [7:0] b, output logic [7:0] r);
    logic [1:0] g;
    for (int i = 3; i >= 0; i--) begin
      pair(b[2*i+1 -: 2], g);
      r[2*i+1 -: 2] = g;
    end
  endtask

  task automatic cs_low();
    cs_n = 0;
    waitc(4);
  endtask

  task automatic cs_high();
    waitc(4);
    cs_n = 1;
    waitc(12);
  endtask

  task automatic frame_wren(input int extra);
    logic [7:0] r;
    logic [1:0] g;
    cs_low();
    send_byte(C_WREN, r);
    for (int i = 0; i < extra; i++) pair(2'b00, g);
    cs_high();
  endtask

  task automatic frame_cmd(input logic [7:0] op, input logic [23:0] addr,
                           input logic [7:0] d0, input logic [7:0] d1,
                           input int nbytes, input int extra, output logic [7:0] rd);
    logic [7:0] r;
    logic [1:0] g;
    int base;
    cs_low();
    base = oe_cnt;
    send_byte(op, r);
    send_byte(addr[23:16], r);
    send_byte(addr[15:8], r);
    for (int i = 3; i >= 1; i--) pair(addr[2*i+1 -: 2], g);
    hdr_oe = oe_cnt - base;
    pair(addr[1:0], g);
    for (int n = 0; n < nbytes; n++) send_byte((n == 0) ? d0 : d1, rd);
    for (int i = 0; i < extra; i++) pair(2'b00, g);
    cs_high();
  endtask

  task automatic peek(input logic [6:0] i, output logic [7:0] v);
    dbg_idx = i;
    waitc(1);
    v = dbg_lock;
  endtask

  initial begin
    logic [7:0] v, rd;
    int base;
    waitc(10);
    rst_n = 1;
    waitc(4);
    // R1 reset state
    chk(dbg_wel == 0, "R1 wel", dbg_wel, 0);
    chk(dq_oe == 0, "R1 oe", dq_oe, 0);
    peek(7'h00, v); chk(v == 0, "R1 reg0", v, 0);
    peek(7'h7F, v); chk(v == 0, "R1 reg127", v, 0);

    // table walk: R3 writes, R6/R7 reads
    foreach (VEC[k]) begin
      if (VEC[k][41:40] == 2'd0) begin
        frame_wren(0);
        chk(dbg_wel == 1, "R2 wel before write", dbg_wel, 1);
        frame_cmd(C_WR, VEC[k][39:16], VEC[k][15:8], 8'h00, 1, 0, rd);
        peek(VEC[k][38:32], v);
        chk(v == VEC[k][7:0], "R3 stored value", v, VEC[k][7:0]);
        chk(dbg_wel == 0, "R3 wel cleared", dbg_wel, 0);
      end else begin
        frame_cmd(C_RD, VEC[k][39:16], 8'h00, 8'h00, 1, 0, rd);
        chk(rd == VEC[k][7:0], "R6 R7 read value", rd, VEC[k][7:0]);
        chk(hdr_oe == 0, "R8 no drive in header", hdr_oe, 0);
        chk(dq_oe == 0, "R8 quiet after frame", dq_oe, 0);
      end
    end

    peek(7'h33, v); chk(v == 0, "R6 untouched reg", v, 0);

    // R10 stray clock after write-enable command
    frame_wren(1);
    chk(dbg_wel == 0, "R10 extra clock", dbg_wel, 0);
    frame_wren(0);
    chk(dbg_wel == 1, "R2 wel set", dbg_wel, 1);

    // R5 select rises mid-byte
    frame_cmd(C_WR, 24'h100000, 8'h03, 8'h00, 1, 2, rd);
    peek(7'h10, v); chk(v == 0, "R5 partial byte reg", v, 0);
    chk(dbg_wel == 1, "R5 wel kept", dbg_wel, 1);

    // R9 unknown command
    base = oe_cnt;
    frame_cmd(8'h9F, 24'h100000, 8'h03, 8'h00, 1, 0, rd);
    peek(7'h10, v); chk(v == 0, "R9 reg unchanged", v, 0);
    chk(dbg_wel == 1, "R9 wel unchanged", dbg_wel, 1);
    chk(oe_cnt == base, "R9 no drive", oe_cnt - base, 0);

    // R11 two data bytes, last wins
    frame_cmd(C_WR, 24'h100000, 8'h01, 8'h02, 2, 0, rd);
    peek(7'h10, v); chk(v == 8'h02, "R11 last byte", v, 8'h02);
    chk(dbg_wel == 0, "R3 wel cleared after R11", dbg_wel, 0);

    // R4 write without latch
    frame_cmd(C_WR, 24'h100000, 8'h03, 8'h00, 1, 0, rd);
    peek(7'h10, v); chk(v == 8'h02, "R4 reg unchanged", v, 8'h02);
    chk(dbg_wel == 0, "R4 wel stays", dbg_wel, 0);

    // R12 read past one byte wraps
    frame_cmd(C_RD, 24'h100000, 8'h00, 8'h00, 2, 0, rd);
    chk(rd == 8'h02, "R12 repeated byte", rd, 8'h02);
    chk(dq_oe == 0, "R8 quiet after long read", dq_oe, 0);

    // R1 reset mid-run
    frame_wren(0);
    rst_n = 0; waitc(3); rst_n = 1; waitc(3);
    chk(dbg_wel == 0, "R1 wel after reset", dbg_wel, 0);
    peek(7'h05, v); chk(v == 0, "R1 reg after reset", v, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule